// File: doc/BRIEF.md
# Table-Driven Moore Sequencer Engine

The block is a finite state machine whose whole transition and output behaviour lives in a lookup memory instead of in gates. Every cycle the registered state code is joined with the gated input signals to form a memory address. The word read there carries two fields: the code of the state to enter next, and the control outputs that belong to that next state. Both fields load into their registers on the same rising edge. The outputs therefore change together with the state, and no decode logic sits after the registers.

A host fills the table through a write port with one enable per byte lane. Writes are accepted only while the sequencer is held in synchronous reset. Each input position can be marked unused by a parameter mask. An unused position reaches the address as 0, so the table never has to store copies of a word for both of its values. The address is the state code in the upper bits and the gated inputs in the lower bits. The defaults (8-bit state, 3 inputs, 16 outputs, 24-bit word, 2048 words) keep elaboration small. Setting IN_W to 9 gives the full 17-bit, 128K-word configuration. The block holds no control flow of its own. Its only fixed behaviours are the reset transition (any state goes to state 0 with the reset output word) and the table step (state S with inputs I goes to the state stored at address {S, I}).

Top module: `seq_engine`

## Requirements
- R1: While `rst` is high at a rising edge, `state_out` becomes 0 and `ctrl_out` becomes the parameter RESET_CTRL (default 16'h5A3C) after that edge.
- R2: The table address is `{state_out, gated inputs}`: state code in address bits [IN_W+STATE_W-1:IN_W], input bit i in address bit i.
- R3: At each rising edge with `rst` low, `state_out` loads bits [23:16] (the upper STATE_W bits) of the word at the current address.
- R4: On the same edge, `ctrl_out` loads bits [15:0] (the lower OUT_W bits) of that same word.
- R5: An input position whose bit in IN_USED (default 3'b011) is 0 is forced to 0 in the address, so toggling it never changes the word read or the next state and outputs.
- R6: With `rst` and `host_we` high, the word at `host_addr` is written lane by lane: byte lane k (bits 8k+7:8k, k = 0..2) takes `host_wdata` only if `host_be[k]` is 1, and the other lanes keep their old contents.
- R7: A host write presented while `rst` is low is ignored, so the table word at `host_addr` is unchanged.
- R8: Reset does not clear the table. Contents written before a reset still drive the transitions after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; also enables table writes |
| seq_in | input | IN_W | Live input signals to the sequencer |
| host_we | input | 1 | Host table write enable |
| host_addr | input | STATE_W+IN_W | Host table write address |
| host_wdata | input | STATE_W+OUT_W | Host table write data |
| host_be | input | (STATE_W+OUT_W)/8 | Host byte-lane write enables |
| state_out | output | STATE_W | Registered current state code |
| ctrl_out | output | OUT_W | Registered control outputs |

## Verification
Four behaviours are checked on every cycle. The reset value of both registers is one. Another is that the state and output registers take the two fields of the word read in the previous cycle. The last two are that the word read stays fixed when only masked input positions move, and that nothing alters the table outside reset. Only the bench can show the full picture. It compares each step with its own model of the table under random inputs, and it covers partial byte-lane writes, a write attempted out of reset, and table retention across repeated resets.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int LANE_W = 8;

    function automatic int lane_count(input int width);
        return (width + LANE_W - 1) / LANE_W;
    endfunction
endpackage

// File: rtl/seq_in_gate.sv
module seq_in_gate #(
    parameter int             IN_W    = 3,
    parameter logic [IN_W-1:0] IN_USED = '1
) (
    input  logic [IN_W-1:0] raw_in,
    output logic [IN_W-1:0] gated_in
);
    // Positions marked unused in IN_USED never reach the table address.
    assign gated_in = raw_in & IN_USED;
endmodule

// File: rtl/seq_lut.sv
module seq_lut #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 24
) (
    input  logic                 clk,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [seq_pkg::lane_count(DATA_W)-1:0] wr_be
);
    localparam int LANES = seq_pkg::lane_count(DATA_W);
    localparam int LW    = seq_pkg::LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    // One storage array per byte lane so each lane has a single writer.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[l]) begin
                lane_mem[wr_addr] <= wr_data[l*LW +: LW];
            end
        end

        // Combinational read: the next-state word is ready within the cycle.
        assign rd_data[l*LW +: LW] = lane_mem[rd_addr];
    end
endmodule

// File: rtl/seq_regs.sv
module seq_regs #(
    parameter int               STATE_W    = 8,
    parameter int               OUT_W      = 16,
    parameter logic [OUT_W-1:0] RESET_CTRL = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [STATE_W+OUT_W-1:0]   word_in,
    output logic [STATE_W-1:0]         state_q,
    output logic [OUT_W-1:0]           ctrl_q
);
    localparam int DATA_W = STATE_W + OUT_W;

    logic [STATE_W-1:0] next_state;
    logic [OUT_W-1:0]   next_ctrl;

    assign next_state = word_in[DATA_W-1:OUT_W];
    assign next_ctrl  = word_in[OUT_W-1:0];

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= next_state;
        end
    end

    // Output register, loaded from the same word on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RESET_CTRL;
        end else begin
            ctrl_q <= next_ctrl;
        end
    end
endmodule

// File: rtl/seq_engine.sv
module seq_engine #(
    parameter int                 STATE_W    = 8,
    parameter int                 IN_W       = 3,
    parameter int                 OUT_W      = 16,
    parameter logic [IN_W-1:0]    IN_USED    = 3'b011,
    parameter logic [OUT_W-1:0]   RESET_CTRL = 16'h5A3C,
    localparam int                ADDR_W     = STATE_W + IN_W,
    localparam int                DATA_W     = STATE_W + OUT_W,
    localparam int                LANES      = seq_pkg::lane_count(DATA_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IN_W-1:0]     seq_in,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [LANES-1:0]    host_be,
    output logic [STATE_W-1:0]  state_out,
    output logic [OUT_W-1:0]    ctrl_out
);
    logic [IN_W-1:0]   in_gated;
    logic [ADDR_W-1:0] lut_addr;
    logic [DATA_W-1:0] lut_word;
    logic              lut_wr;

    seq_in_gate #(
        .IN_W    (IN_W),
        .IN_USED (IN_USED)
    ) u_gate (
        .raw_in   (seq_in),
        .gated_in (in_gated)
    );

    assign lut_addr = {state_out, in_gated};

    // Table loading is allowed only while the sequencer is held in reset.
    assign lut_wr = host_we & rst;

    seq_lut #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lut (
        .clk     (clk),
        .rd_addr (lut_addr),
        .rd_data (lut_word),
        .wr_en   (lut_wr),
        .wr_addr (host_addr),
        .wr_data (host_wdata),
        .wr_be   (host_be)
    );

    seq_regs #(
        .STATE_W    (STATE_W),
        .OUT_W      (OUT_W),
        .RESET_CTRL (RESET_CTRL)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .word_in (lut_word),
        .state_q (state_out),
        .ctrl_q  (ctrl_out)
    );
endmodule

// File: rtl/seq_engine_chk.sv
module seq_engine_chk #(
    parameter int               STATE_W    = 8,
    parameter int               IN_W       = 3,
    parameter int               OUT_W      = 16,
    parameter logic [IN_W-1:0]  IN_USED    = '1,
    parameter logic [OUT_W-1:0] RESET_CTRL = '0
) (
    input logic                        clk,
    input logic                        rst,
    input logic [IN_W-1:0]             seq_in,
    input logic [STATE_W-1:0]          state_out,
    input logic [OUT_W-1:0]            ctrl_out,
    input logic [STATE_W+OUT_W-1:0]    lut_word
);
    localparam int DATA_W = STATE_W + OUT_W;

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (state_out == '0) && (ctrl_out == RESET_CTRL));

    // R3
    state_from_word_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> state_out == $past(lut_word[DATA_W-1:OUT_W]));

    // R4
    ctrl_from_word_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ctrl_out == $past(lut_word[OUT_W-1:0]));

    // R5
    masked_input_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $stable(state_out) &&
         (((seq_in ^ $past(seq_in)) & IN_USED) == '0)) |-> $stable(lut_word));

    // R7
    no_run_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $stable(state_out) && $stable(seq_in)) |-> $stable(lut_word));
endmodule

bind seq_engine seq_engine_chk #(
    .STATE_W    (STATE_W),
    .IN_W       (IN_W),
    .OUT_W      (OUT_W),
    .IN_USED    (IN_USED),
    .RESET_CTRL (RESET_CTRL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seq_in    (seq_in),
    .state_out (state_out),
    .ctrl_out  (ctrl_out),
    .lut_word  (lut_word)
);

// File: tb/test_seq_engine.sv
`timescale 1ns/1ps
module test_seq_engine;
    localparam int          STATE_W = 8;
    localparam int          IN_W    = 3;
    localparam int          OUT_W   = 16;
    localparam logic [2:0]  MASK    = 3'b011;
    localparam logic [15:0] RCTRL   = 16'h5A3C;
    localparam int          AW      = STATE_W + IN_W;
    localparam int          DW      = STATE_W + OUT_W;
    localparam int          DEPTH   = 1 << AW;
    localparam real         PER     = 20.0;

    logic          clk = 0;
    logic          rst = 1;
    logic [2:0]    seq_in = '0;
    logic          host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [2:0]    host_be = '0;
    logic [7:0]    state_out;
    logic [15:0]   ctrl_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] model [DEPTH];
    logic [7:0]    exp_state;

    always #(PER/2) clk = ~clk;

    seq_engine i_seq_engine (
        .clk(clk), .rst(rst), .seq_in(seq_in), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .state_out(state_out), .ctrl_out(ctrl_out)
    );

    function automatic logic [AW-1:0] addr_of(input logic [7:0] s, input logic [2:0] i);
        return {s, i & MASK};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [2:0] be);
        logic [DW-1:0] r = old;
        for (int k = 0; k < 3; k++) if (be[k]) r[k*8 +: 8] = nw[k*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One run cycle: drive inputs, then compare both registers after the edge.
    task automatic step(input logic [2:0] in, input string tag);
        logic [DW-1:0] w;
        @(negedge clk);
        rst = 0;
        host_we = 0;
        seq_in = in;
        w = model[addr_of(exp_state, in)];
        @(posedge clk);
        #1;
        check({state_out, ctrl_out} == w, tag, {state_out, ctrl_out}, w);
        exp_state = w[23:16];
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1;
        host_we = 0;
        @(posedge clk);
        #1;
        check(state_out == 0 && ctrl_out == RCTRL, tag, {state_out, ctrl_out}, {8'h00, RCTRL});
        exp_state = '0;
    endtask

    initial begin
        logic [DW-1:0] w;
        logic [AW-1:0] tgt;
        void'($urandom(32'd20240611));
        exp_state = '0;

        // Fill the whole table while in reset.
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            host_we = 1;
            host_addr = AW'(a);
            host_wdata = DW'($urandom);
            host_be = 3'b111;
            model[a] = host_wdata;
        end
        @(negedge clk);
        host_we = 0;
        @(posedge clk);
        #1;
        // R1: reset state and reset output word
        check(state_out == 0 && ctrl_out == RCTRL, "R1 reset", {state_out, ctrl_out}, {8'h00, RCTRL});

        // R6: partial lane writes in reset
        @(negedge clk);
        host_we = 1; host_addr = addr_of(8'h00, 3'b001);
        host_wdata = 24'hC3_E1_7F; host_be = 3'b010;
        model[host_addr] = merge(model[host_addr], host_wdata, 3'b010);
        @(negedge clk);
        host_addr = addr_of(8'h00, 3'b010);
        host_wdata = 24'h12_34_56; host_be = 3'b101;
        model[host_addr] = merge(model[host_addr], host_wdata, 3'b101);
        @(negedge clk);
        host_addr = addr_of(8'h00, 3'b011);
        host_wdata = 24'hFF_FF_FF; host_be = 3'b000;
        @(negedge clk);
        host_we = 0;
        step(3'b001, "R6 lane1 write");
        do_reset("R1 re-reset");
        step(3'b010, "R6 lanes0+2 write");
        do_reset("R1 re-reset");
        step(3'b011, "R6 no-lane write");

        // R5: unused input bit 2 toggled against the same address
        do_reset("R1 re-reset");
        step(3'b101, "R5 masked bit set");
        do_reset("R1 re-reset");
        step(3'b001, "R5 masked bit clear");

        // R7: write attempted while running, target the next cycle's address
        begin
            w = model[addr_of(exp_state, 3'b010)];
            tgt = addr_of(w[23:16], 3'b001);
            @(negedge clk);
            rst = 0;
            seq_in = 3'b010;
            host_we = 1; host_addr = tgt; host_wdata = ~model[tgt]; host_be = 3'b111;
            @(posedge clk);
            #1;
            check({state_out, ctrl_out} == w, "R7 run write cycle", {state_out, ctrl_out}, w);
            exp_state = w[23:16];
            step(3'b001, "R7 ignored write");
        end

        // R2 R3 R4 R8: random stepping with periodic resets and no rewrites
        for (int n = 0; n < 3000; n++) begin
            if (n % 500 == 499) do_reset("R1 R8 reset mid-run");
            else step(3'($urandom), "R2 R3 R4 R8 random step");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PER * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule